// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block collects a set of level-sensitive interrupt lines (32 by default) and presents them to two independent processor targets. Every target owns a latched cause register and an enable register. A source that is high on a clock edge sets its cause bit in both targets at once. Software acknowledges a request by writing a 1 to that cause bit. Each target raises its own registered interrupt line whenever it has at least one cause bit that is also enabled.

Software reaches the registers through a small word-addressed window on a 32-bit request/response bus. The block accepts a request on every cycle and returns read data one cycle later. For each target, a read-only "lowest pending" word returns the smallest pending enabled index, so the service routine needs no bit scan. To silence a target, clear its enable register and then write all ones to its cause register.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, every cause and enable register reads 0, both interrupt outputs are low and no read response is pending.
- R2: A source that is high on a rising edge sets its cause bit in both targets' cause registers, whatever the enable bits are. The bit stays set after the source drops.
- R3: A write to a cause register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If a cause bit is cleared in the same cycle that its source is high, the bit stays set.
- R5: The enable registers are read/write. Bit n set to 1 enables source n for that target. Writing an enable register does not change any cause bit.
- R6: Interrupt output bit t (bit 0 = target A, bit 1 = target B) is registered. It goes high one cycle after target t's cause AND enable becomes nonzero, and low one cycle after it becomes zero.
- R7: Accesses to one target's registers leave the other target's registers unchanged.
- R8: Word map (byte offsets): A cause 0x00, A enable 0x04, B cause 0x08, B enable 0x0C, A lowest-pending 0x10, B lowest-pending 0x14. A lowest-pending word has bit 31 = 1 and bits 4:0 = the lowest index of cause AND enable, or reads all zeros when nothing is pending.
- R9: After writing 0 to a target's enable register and then all ones to its cause register, with the sources low, that target's output is low and its lowest-pending word reads 0.
- R10: Any other offset (0x18, 0x1C, or any offset not a multiple of 4) reads 0, and writes to it change no register.
- R11: req_ready is always high. rsp_valid is high exactly in the cycle after an accepted read. rsp_rdata returns the register value from before the edge that accepted the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 32 | Level-sensitive interrupt sources |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset into the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 2 | Per-target interrupt outputs (bit 0 = A, bit 1 = B) |

## Verification
The bench walks a single set bit through every source position. This separates latching, per-target clearing and cross-target independence for each bit. A second sweep raises a thermometer of sources starting at each index in turn, under two different enable patterns. It checks that the lowest-pending word picks the lowest enabled bit and not just any set bit, and that a target whose enables exclude every pending bit stays quiet. Further directed cases cover a clear that collides with a held source, the silencing sequence, enable read-back under alternating patterns, and unmapped and unaligned offsets.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FP_VALID  = 31;

  // lowest set index of a pending vector, packed with a valid flag
  function automatic logic [WORD_W-1:0] fp_encode(input logic [WORD_W-1:0] pend);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        w = WORD_W'(i);
        w[FP_VALID] = 1'b1;
      end
    end
    return w;
  endfunction

  // next cause value: clear written ones, then let live sources win
  function automatic logic [WORD_W-1:0] cause_next(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] clr,
                                                   input logic [WORD_W-1:0] src);
    return (cur & ~clr) | src;
  endfunction

endpackage

// File: rtl/dirq_target.sv
module dirq_target #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] wr_bits,
  output logic [N_SRC-1:0] cause_q,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] pend,
  output logic             irq_q
);
  import dirq_pkg::*;

  logic [N_SRC-1:0] clr_bits;
  logic [N_SRC-1:0] cause_d;
  logic [WORD_W-1:0] cause_d_w;

  assign clr_bits  = clr_we ? wr_bits : '0;
  assign cause_d_w = cause_next(WORD_W'(cause_q), WORD_W'(clr_bits), WORD_W'(src_lvl));
  assign cause_d   = cause_d_w[N_SRC-1:0];
  assign pend      = cause_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      if (mask_we) mask_q <= wr_bits;
      irq_q <= |pend;
    end
  end

  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(src_lvl)) == $past(src_lvl)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((cause_q & $past(wr_bits) & ~$past(src_lvl)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == (($past(cause_q) & $past(mask_q)) != '0)));

endmodule

// File: rtl/dirq_regbus.sv
module dirq_regbus #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_TGT = 2,
  parameter int unsigned AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [N_SRC-1:0] cause_q [N_TGT],
  input  logic [N_SRC-1:0] mask_q  [N_TGT],
  input  logic [31:0]      fp_word [N_TGT],
  output logic [N_TGT-1:0] clr_we,
  output logic [N_TGT-1:0] mask_we,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata
);
  localparam int unsigned WIDX_W  = AW - 2;
  localparam int unsigned FP_BASE = 2 * N_TGT;
  localparam int unsigned N_WORDS = 3 * N_TGT;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic              wr_acc;
  logic              rd_acc;
  logic              unmapped;
  logic [31:0]       rd_mux;

  assign req_ready = 1'b1;
  assign widx      = req_addr[AW-1:2];
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign wr_acc    = req_valid && req_ready && req_write;
  assign rd_acc    = req_valid && req_ready && !req_write;
  assign unmapped  = !aligned || (int'(widx) >= int'(N_WORDS));

  always_comb begin
    clr_we  = '0;
    mask_we = '0;
    rd_mux  = '0;
    if (!unmapped) begin
      for (int t = 0; t < int'(N_TGT); t++) begin
        if (int'(widx) == 2 * t) begin
          clr_we[t] = wr_acc;
          rd_mux    = 32'(cause_q[t]);
        end
        if (int'(widx) == 2 * t + 1) begin
          mask_we[t] = wr_acc;
          rd_mux     = 32'(mask_q[t]);
        end
        if (int'(widx) == int'(FP_BASE) + t) begin
          rd_mux = fp_word[t];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      rsp_rdata <= rd_acc ? rd_mux : '0;
    end
  end

  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(rd_acc)));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && unmapped) |=> (rsp_rdata == 32'd0));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_we, mask_we}));

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_TGT = 2,
  parameter int unsigned AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_src,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic [N_TGT-1:0] irq_out
);
  import dirq_pkg::*;

  logic [N_SRC-1:0] cause_q [N_TGT];
  logic [N_SRC-1:0] mask_q  [N_TGT];
  logic [N_SRC-1:0] pend    [N_TGT];
  logic [31:0]      fp_word [N_TGT];
  logic [N_TGT-1:0] clr_we;
  logic [N_TGT-1:0] mask_we;

  for (genvar t = 0; t < int'(N_TGT); t++) begin : g_tgt
    logic [31:0] pend_w;
    assign pend_w     = 32'(pend[t]);
    assign fp_word[t] = fp_encode(pend_w);

    dirq_target #(.N_SRC(N_SRC)) u_tgt (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_lvl (irq_src),
      .clr_we  (clr_we[t]),
      .mask_we (mask_we[t]),
      .wr_bits (req_wdata[N_SRC-1:0]),
      .cause_q (cause_q[t]),
      .mask_q  (mask_q[t]),
      .pend    (pend[t]),
      .irq_q   (irq_out[t])
    );

    p_fp_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fp_word[t][31] |-> (pend_w[fp_word[t][4:0]] &&
                          ((pend_w & ((32'd1 << fp_word[t][4:0]) - 32'd1)) == 32'd0)));

    p_fp_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fp_word[t][31] |-> (pend_w == 32'd0 && fp_word[t] == 32'd0));
  end

  dirq_regbus #(.N_SRC(N_SRC), .N_TGT(N_TGT), .AW(AW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .fp_word   (fp_word),
    .clr_we    (clr_we),
    .mask_we   (mask_we),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: tb/dual_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dual_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [4:0] A_CAUSE = 5'h00, A_EN = 5'h04, B_CAUSE = 5'h08,
                         B_EN = 5'h0C, A_FP = 5'h10, B_FP = 5'h14;

  always #2.5 clk = ~clk;

  dual_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1) begin
      errors++;
      $display("FAIL R11: rsp_valid actual %b expected 1", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    irq_src = v;
    @(negedge clk);
    irq_src = '0;
  endtask

  // expected lowest-pending word, computed by arithmetic on the index
  function automatic logic [31:0] fp_exp(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'h8000_0000 + 32'(i);
    return 32'd0;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 irq", 32'(irq_out), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11 ready", 32'(req_ready), 32'd1);
    rd(A_CAUSE, d); chk("R1 A cause", d, 0);
    rd(A_EN, d);    chk("R1 A en", d, 0);
    rd(B_CAUSE, d); chk("R1 B cause", d, 0);
    rd(B_EN, d);    chk("R1 B en", d, 0);
    rd(A_FP, d);    chk("R1 A fp", d, 0);
    @(negedge clk);
    chk("R11 no rsp when idle", 32'(rsp_valid), 32'd0);

    // R2/R3/R7: walking single bit
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'd1 << i;
      pulse(b);
      rd(A_CAUSE, d); chk("R2 A latch", d, b);
      rd(B_CAUSE, d); chk("R2 B latch", d, b);
      wr(A_CAUSE, b);
      rd(A_CAUSE, d); chk("R3 A clear", d, 0);
      rd(B_CAUSE, d); chk("R7 B untouched", d, b);
      wr(B_CAUSE, b);
      rd(B_CAUSE, d); chk("R3 B clear", d, 0);
    end
    // R6: no enables -> outputs low
    pulse(32'h0000_00F0);
    @(negedge clk);
    chk("R6 masked low", 32'(irq_out), 0);
    // R3: zero bits have no effect
    wr(A_CAUSE, 32'h0000_000F);
    rd(A_CAUSE, d); chk("R3 zeros keep", d, 32'h0000_00F0);
    wr(A_CAUSE, 32'hFFFF_FFFF); wr(B_CAUSE, 32'hFFFF_FFFF);

    // R5: enable read-back, cause untouched
    pulse(32'h0000_0100);
    wr(A_EN, 32'hA5A5_5A5A); wr(B_EN, 32'h5A5A_A5A5);
    rd(A_EN, d); chk("R5 A en", d, 32'hA5A5_5A5A);
    rd(B_EN, d); chk("R5 B en", d, 32'h5A5A_A5A5);
    rd(A_CAUSE, d); chk("R5 cause kept", d, 32'h0000_0100);
    wr(A_CAUSE, 32'hFFFF_FFFF); wr(B_CAUSE, 32'hFFFF_FFFF);

    // R8/R6: thermometer sweep, A all enabled, B only bit 31
    wr(A_EN, 32'hFFFF_FFFF); wr(B_EN, 32'h8000_0000);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] v;
      v = 32'hFFFF_FFFF << i;
      pulse(v);
      rd(A_FP, d); chk("R8 A fp", d, fp_exp(v));
      rd(B_FP, d); chk("R8 B fp", d, fp_exp(v & 32'h8000_0000));
      chk("R6 both high", 32'(irq_out), 32'd3);
      wr(A_CAUSE, 32'hFFFF_FFFF); wr(B_CAUSE, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R6 low after clear", 32'(irq_out), 0);
    end
    pulse(32'h0000_0001);
    rd(B_FP, d); chk("R8 B fp none", d, 0);
    chk("R6 only A", 32'(irq_out), 32'd1);
    rd(A_FP, d); chk("R8 A fp bit0", d, 32'h8000_0000);

    // R4: clear collides with held source
    @(negedge clk);
    irq_src = 32'h0000_0008;
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_CAUSE; req_wdata = 32'h0000_0008;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; irq_src = '0;
    rd(A_CAUSE, d); chk("R4 set wins", d, 32'h0000_0009);

    // R9: quiesce A
    wr(A_EN, 32'd0); wr(A_CAUSE, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 A quiet", 32'(irq_out[0]), 0);
    rd(A_FP, d); chk("R9 A fp", d, 0);
    rd(A_CAUSE, d); chk("R9 A cause", d, 0);

    // R10: unmapped and unaligned offsets
    rd(B_EN, d); chk("R10 B en before", d, 32'h8000_0000);
    wr(5'h18, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h0D, 32'h0000_0000); wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h18, d); chk("R10 rd 0x18", d, 0);
    rd(5'h1C, d); chk("R10 rd 0x1C", d, 0);
    rd(5'h0D, d); chk("R10 rd unaligned", d, 0);
    rd(B_EN, d); chk("R10 B en kept", d, 32'h8000_0000);
    rd(B_CAUSE, d); chk("R10 B cause kept", d, 32'h0000_0009);
    rd(A_EN, d); chk("R10 A en kept", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule